// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block drives the isolation and power-switch controls of one switchable power island, such as a graphics or video domain. Software writes request bits into a control register. The sequencer then steps the island down or up through two timed phases, each counted in bus clock cycles. The length of each phase comes from a pair of 6-bit delay fields, one pair for power-down and one pair for power-up.

For power-down, the island is isolated first and the switch is opened after the first delay. The sequence ends after the second delay. For power-up, the switch closes at once and isolation is lifted once both delays have run out. A power-down request has effect only while the domain's gating-enable bit is set. Request bits clear themselves when their sequence finishes, and a busy flag is visible on a port and in the control register.

Software reaches four registers through a simple write-strobe / combinational-read port. A write takes effect on the clock edge at which `bus_wr_en` is high. A read returns the addressed register on `bus_rdata` in the same cycle.

Top module: `pgs_domain_seq`

## Requirements
- R1: After reset, `iso_en`=0, `pwr_sw_on`=1 and `busy`=0, and every register reads 0.
- R2: Register map. Offset 0x260 holds the gating enable in bit 0. Offset 0x264 holds the power-up first delay in bits [5:0] and the second delay in bits [13:8]. Offset 0x268 holds the power-down first delay in [5:0] and the second delay in [13:8]. All other bits of these registers, and any unmapped offset, read 0.
- R3: A power-down starts with a write of bit 0 of control offset 0x000 while idle with gating enabled. It sets `iso_en` on the write edge, keeps the switch state for N1 cycles, and then drives `pwr_sw_on` low.
- R4: A sequence keeps `busy` high for exactly N1+N2 cycles after its write edge. Its request bit reads 1 in the control register during that time, and clears when the sequence ends. Control read layout: bit 0 = down request, bit 1 = up request, bit 2 = busy.
- R5: A power-up is started by bit 1 of the control register. It drives `pwr_sw_on` high on the write edge, keeps the isolation state for N1+N2 cycles, and then clears `iso_en`.
- R6: A delay field of 0 counts as one cycle. Here N = field value, or 1 when the field is 0.
- R7: A power-down request while the gating-enable bit is 0 is ignored: outputs, busy and request bits do not change.
- R8: A control write with both bits 1 starts a power-up only.
- R9: Control writes while busy are ignored, and the running sequence keeps its timing.
- R10: Delay fields are captured when a sequence starts. Timing register writes during a sequence affect only later sequences.
- R11: `pwr_sw_on` is never 0 while `iso_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all delays count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register |
| iso_en | output | 1 | Domain isolation enable |
| pwr_sw_on | output | 1 | Domain power switch closed (powered) |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench times every phase boundary against delays computed from its own shadow of the timing registers. An off-by-one counter would move the switch or isolation edge by a cycle. A zero-field case that skipped the phase would end a sequence early.

Several corner cases are targeted directly:
- Power-down with gating disabled: a design that ignores the enable would drop the switch.
- A write with both request bits set: a design with the wrong priority would isolate the domain instead of powering it.
- A control write injected mid-sequence: a design that restarts would stretch `busy`.
- A timing write injected mid-sequence: a design that reads live fields would change the second phase.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int DLY_W         = 6;
    localparam int FIRST_LSB     = 0;
    localparam int SECOND_LSB    = 8;
    localparam int CTRL_DN_BIT   = 0;
    localparam int CTRL_UP_BIT   = 1;
    localparam int CTRL_BUSY_BIT = 2;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_GATE = 'h260;
    localparam int OFS_UPT  = 'h264;
    localparam int OFS_DNT  = 'h268;

    typedef struct packed {
        logic [DLY_W-1:0] second;
        logic [DLY_W-1:0] first;
    } dly_pair_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_SW,
        ST_UP_SW,
        ST_UP_ISO
    } seq_state_t;

    // counter preload: a phase of N cycles loads N-1; a zero field acts as 1
    function automatic logic [DLY_W-1:0] phase_load(input logic [DLY_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
    import pgs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              st_busy,
    input  logic              st_req_up,
    input  logic              st_req_dn,
    output logic [DATA_W-1:0] rdata,
    output logic              gate_en,
    output dly_pair_t         up_dly,
    output dly_pair_t         dn_dly,
    output logic              ctrl_wr,
    output logic              ctrl_up,
    output logic              ctrl_dn
);

    int addr_i;
    assign addr_i = int'(addr);

    assign ctrl_wr = wr_en && (addr_i == OFS_CTRL);
    assign ctrl_up = wdata[CTRL_UP_BIT];
    assign ctrl_dn = wdata[CTRL_DN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_en <= 1'b0;
            up_dly  <= '0;
            dn_dly  <= '0;
        end else if (wr_en) begin
            if (addr_i == OFS_GATE) begin
                gate_en <= wdata[0];
            end
            if (addr_i == OFS_UPT) begin
                up_dly.first  <= wdata[FIRST_LSB +: DLY_W];
                up_dly.second <= wdata[SECOND_LSB +: DLY_W];
            end
            if (addr_i == OFS_DNT) begin
                dn_dly.first  <= wdata[FIRST_LSB +: DLY_W];
                dn_dly.second <= wdata[SECOND_LSB +: DLY_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_i == OFS_CTRL) begin
            rdata[CTRL_DN_BIT]   = st_req_dn;
            rdata[CTRL_UP_BIT]   = st_req_up;
            rdata[CTRL_BUSY_BIT] = st_busy;
        end else if (addr_i == OFS_GATE) begin
            rdata[0] = gate_en;
        end else if (addr_i == OFS_UPT) begin
            rdata[FIRST_LSB +: DLY_W]  = up_dly.first;
            rdata[SECOND_LSB +: DLY_W] = up_dly.second;
        end else if (addr_i == OFS_DNT) begin
            rdata[FIRST_LSB +: DLY_W]  = dn_dly.first;
            rdata[SECOND_LSB +: DLY_W] = dn_dly.second;
        end
    end

endmodule

// File: rtl/pgs_phase_timer.sv
module pgs_phase_timer
    import pgs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expire
);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/pgs_seq_fsm.sv
module pgs_seq_fsm
    import pgs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_up,
    input  logic             ctrl_dn,
    input  logic             gate_en,
    input  dly_pair_t        up_dly,
    input  dly_pair_t        dn_dly,
    input  logic             expire,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    output logic             iso_en,
    output logic             sw_on,
    output logic             busy,
    output logic             req_up,
    output logic             req_dn
);

    seq_state_t       state;
    logic [DLY_W-1:0] hold2;
    logic             idle, go_up, go_dn, first_phase;

    assign idle        = (state == ST_IDLE);
    assign go_up       = idle && ctrl_wr && ctrl_up;
    assign go_dn       = idle && ctrl_wr && !ctrl_up && ctrl_dn && gate_en;
    assign first_phase = (state == ST_DN_ISO) || (state == ST_UP_SW);

    always_comb begin
        tmr_load = go_up || go_dn || (first_phase && expire);
        if (go_up) begin
            tmr_val = phase_load(up_dly.first);
        end else if (go_dn) begin
            tmr_val = phase_load(dn_dly.first);
        end else begin
            tmr_val = phase_load(hold2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hold2  <= '0;
            iso_en <= 1'b0;
            sw_on  <= 1'b1;
            req_up <= 1'b0;
            req_dn <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go_up) begin
                        state  <= ST_UP_SW;
                        sw_on  <= 1'b1;
                        req_up <= 1'b1;
                        hold2  <= up_dly.second;
                    end else if (go_dn) begin
                        state  <= ST_DN_ISO;
                        iso_en <= 1'b1;
                        req_dn <= 1'b1;
                        hold2  <= dn_dly.second;
                    end
                end
                ST_DN_ISO: if (expire) begin
                    state <= ST_DN_SW;
                    sw_on <= 1'b0;
                end
                ST_DN_SW: if (expire) begin
                    state  <= ST_IDLE;
                    req_dn <= 1'b0;
                end
                ST_UP_SW: if (expire) begin
                    state <= ST_UP_ISO;
                end
                ST_UP_ISO: if (expire) begin
                    state  <= ST_IDLE;
                    iso_en <= 1'b0;
                    req_up <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = !idle;

endmodule

// File: rtl/pgs_domain_seq.sv
module pgs_domain_seq
    import pgs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              iso_en,
    output logic              pwr_sw_on,
    output logic              busy
);

    logic             gate_en, ctrl_wr, ctrl_up, ctrl_dn;
    logic             req_up, req_dn, expire, tmr_load;
    logic [DLY_W-1:0] tmr_val;
    dly_pair_t        up_dly, dn_dly;

    pgs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .st_busy   (busy),
        .st_req_up (req_up),
        .st_req_dn (req_dn),
        .rdata     (bus_rdata),
        .gate_en   (gate_en),
        .up_dly    (up_dly),
        .dn_dly    (dn_dly),
        .ctrl_wr   (ctrl_wr),
        .ctrl_up   (ctrl_up),
        .ctrl_dn   (ctrl_dn)
    );

    pgs_phase_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    pgs_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_up  (ctrl_up),
        .ctrl_dn  (ctrl_dn),
        .gate_en  (gate_en),
        .up_dly   (up_dly),
        .dn_dly   (dn_dly),
        .expire   (expire),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .iso_en   (iso_en),
        .sw_on    (pwr_sw_on),
        .busy     (busy),
        .req_up   (req_up),
        .req_dn   (req_dn)
    );

endmodule

// File: rtl/pgs_domain_seq_chk.sv
module pgs_domain_seq_chk (
    input logic clk,
    input logic rst,
    input logic iso_en,
    input logic pwr_sw_on,
    input logic busy,
    input logic req_up,
    input logic req_dn,
    input logic gate_en,
    input logic ctrl_wr,
    input logic ctrl_up,
    input logic ctrl_dn
);

    a_r11_iso_covers_off: assert property (@(posedge clk) disable iff (rst)
        !pwr_sw_on |-> iso_en);

    a_r4_one_req_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones({req_up, req_dn}) == 1));

    a_r4_no_req_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!req_up && !req_dn));

    a_r7_gate_blocks_down: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && ctrl_dn && !ctrl_up && !gate_en) |=> !busy);

    a_r8_up_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && ctrl_up) |=> (req_up && !req_dn && pwr_sw_on));

    a_r3_iso_first: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && ctrl_dn && !ctrl_up && gate_en) |=> (iso_en && req_dn));

    a_r9_up_not_replaced: assert property (@(posedge clk) disable iff (rst)
        (busy && req_up) |=> (!req_dn && (req_up || !busy)));

    a_r9_dn_not_replaced: assert property (@(posedge clk) disable iff (rst)
        (busy && req_dn) |=> (!req_up && (req_dn || !busy)));

    a_r5_release_ends_up: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_en) |-> (!busy && $past(req_up)));

endmodule

bind pgs_domain_seq pgs_domain_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iso_en    (iso_en),
    .pwr_sw_on (pwr_sw_on),
    .busy      (busy),
    .req_up    (req_up),
    .req_dn    (req_dn),
    .gate_en   (gate_en),
    .ctrl_wr   (ctrl_wr),
    .ctrl_up   (ctrl_up),
    .ctrl_dn   (ctrl_dn)
);

// File: tb/pgs_domain_seq_test.sv
module pgs_domain_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        iso_en, pwr_sw_on, busy;

    always #5 clk = ~clk;

    pgs_domain_seq uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .iso_en    (iso_en),
        .pwr_sw_on (pwr_sw_on),
        .busy      (busy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench shadow of the programmed state
    bit sh_gate;
    int up1, up2, dn1, dn2;
    bit m_iso, m_sw;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff(int f);
        return (f == 0) ? 1 : f;
    endfunction

    function automatic void shadow_write(int a, logic [31:0] d);
        if (a == 'h260) sh_gate = d[0];
        if (a == 'h264) begin up1 = int'(d[5:0]); up2 = int'(d[13:8]); end
        if (a == 'h268) begin dn1 = int'(d[5:0]); dn2 = int'(d[13:8]); end
    endfunction

    function automatic logic [31:0] reg_exp(int a);
        if (a == 'h260) return {31'b0, sh_gate};
        if (a == 'h264) return 32'(up2 * 256 + up1);
        if (a == 'h268) return 32'(dn2 * 256 + dn1);
        return 32'h0;
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = 12'(a);
        bus_wdata = d;
        @(posedge clk);
        #1 bus_wr_en = 1'b0;
        shadow_write(a, d);
    endtask

    task automatic rd_chk(string req, int a);
        @(negedge clk);
        bus_addr = 12'(a);
        #1 chk(req, bus_rdata, reg_exp(a));
    endtask

    // inject: 0 none, 1 control write mid-run, 2 timing write mid-run
    task automatic ctrl_seq(string tag, logic [1:0] req, int inject, logic [31:0] inj_data);
        bit is_up, is_dn;
        int n1, n2, total;
        bit e_iso, e_sw, e_busy;
        is_up = req[1];
        is_dn = !req[1] && req[0] && sh_gate;
        n1 = is_up ? eff(up1) : eff(dn1);
        n2 = is_up ? eff(up2) : eff(dn2);
        total = n1 + n2;
        wr('h000, {30'b0, req});
        if (!is_up && !is_dn) begin
            for (int t = 1; t <= 4; t++) begin
                @(negedge clk);
                chk(tag, busy, 1'b0);
                chk(tag, iso_en, m_iso);
                chk(tag, pwr_sw_on, m_sw);
            end
            bus_addr = 12'h000;
            #1 chk(tag, bus_rdata, 32'h0);
            return;
        end
        for (int t = 1; t <= total + 1; t++) begin
            @(negedge clk);
            e_busy = (t <= total);
            if (is_up) begin
                e_sw  = 1'b1;
                e_iso = (t <= total) ? m_iso : 1'b0;
                chk("R5", pwr_sw_on, e_sw);
                chk("R5", iso_en, e_iso);
            end else begin
                e_iso = 1'b1;
                e_sw  = (t <= n1) ? m_sw : 1'b0;
                chk("R3", iso_en, e_iso);
                chk("R3", pwr_sw_on, e_sw);
            end
            chk(tag, busy, e_busy);
            if (!pwr_sw_on) chk("R11", iso_en, 1'b1);
            if (t == 1) begin
                bus_addr = 12'h000;
                #1 chk("R4", bus_rdata, is_up ? 32'h6 : 32'h5);
                if (inject != 0) begin
                    bus_wr_en = 1'b1;
                    bus_addr  = (inject == 1) ? 12'h000 : (is_up ? 12'h264 : 12'h268);
                    bus_wdata = inj_data;
                end
            end else if (t == 2 && inject != 0) begin
                bus_wr_en = 1'b0;
                shadow_write(int'(bus_addr), inj_data);
            end
        end
        bus_addr = 12'h000;
        #1 chk("R4", bus_rdata, 32'h0);
        m_iso = is_up ? 1'b0 : 1'b1;
        m_sw  = is_up ? 1'b1 : 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
        sh_gate = 0; up1 = 0; up2 = 0; dn1 = 0; dn2 = 0;
        m_iso = 0; m_sw = 1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1", iso_en, 1'b0);
        chk("R1", pwr_sw_on, 1'b1);
        chk("R1", busy, 1'b0);
        rd_chk("R1", 'h000);
        rd_chk("R1", 'h260);
        rd_chk("R1", 'h264);
        rd_chk("R1", 'h268);

        // R2: field masking and unmapped offsets
        wr('h264, 32'hFFFF_FFFF);
        rd_chk("R2", 'h264);
        chk("R2", reg_exp('h264), 32'h3F3F);
        wr('h268, 32'hA5C1_D2E3);
        rd_chk("R2", 'h268);
        wr('h260, 32'hFFFF_FFFE);
        rd_chk("R2", 'h260);
        rd_chk("R2", 'h100);
        rd_chk("R2", 'h26C);

        // R7: power-down ignored with gating disabled
        ctrl_seq("R7", 2'b01, 0, 0);

        // R6: zero fields act as one cycle each
        wr('h260, 32'h1);
        wr('h264, 32'h0);
        wr('h268, 32'h0);
        ctrl_seq("R6", 2'b01, 0, 0);
        ctrl_seq("R6", 2'b10, 0, 0);

        // R3/R4/R5 with maximum fields
        wr('h264, 32'h3F3F);
        wr('h268, 32'h3F3F);
        ctrl_seq("R4", 2'b01, 0, 0);
        ctrl_seq("R4", 2'b10, 0, 0);

        // R8: both request bits -> power-up only
        wr('h268, 32'h0305);
        wr('h264, 32'h0402);
        ctrl_seq("R4", 2'b01, 0, 0);
        ctrl_seq("R8", 2'b11, 0, 0);

        // R9: control write during a run is ignored
        ctrl_seq("R9", 2'b01, 1, 32'h3);
        ctrl_seq("R9", 2'b10, 1, 32'h1);

        // R10: timing write during a run applies to the next run only
        ctrl_seq("R10", 2'b01, 2, 32'h0102);
        rd_chk("R10", 'h268);
        ctrl_seq("R10", 2'b10, 2, 32'h0201);
        rd_chk("R10", 'h264);
        ctrl_seq("R10", 2'b01, 0, 0);

        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            logic [31:0] rv;
            int inj;
            rv = $urandom();
            wr('h260, {31'b0, (rv[3:0] != 4'h0)});
            wr('h264, $urandom() & 32'hFFFF_3F3F);
            wr('h268, $urandom() & 32'hFFFF_3F3F);
            if (rv[4]) rd_chk("R2", 'h264);
            if (rv[5]) rd_chk("R2", 'h268);
            inj = int'($urandom_range(0, 2));
            ctrl_seq("R4", rv[9:8], inj, $urandom() & 32'h3F3F);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule